// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block produces the internal reset of a small microcontroller. Its reset request input is active high and asynchronous. While the request is high, the internal reset output is forced high at once, with no clock involved. After the request falls, the output stays high through three timed phases. Each phase runs in its own clock domain and is started by the previous phase through a two-flop synchroniser.

The first phase waits for the supply to settle by counting a fixed number of cycles of a slow oscillator of about 128 kHz. It never looks at the supply level, so the full count is always run. A strap input chooses a long count or a short count. The second phase counts a fixed number of cycles of the fast calibrated oscillator so that this oscillator is stable before it is used. The third phase runs on the system clock. It issues one read strobe per cycle to non-volatile storage, with a word address that counts up from zero, to fetch calibration and configuration words. When the last word has been read, the internal reset is released.

A phase status output, in the system clock domain, shows how far the sequence has progressed. If the reset request rises again in any phase, every domain is reset and the sequence starts over from the first phase after the next release. After release, the system clock runs from the 8 MHz internal oscillator divided by 8. That selection is made outside this block, which only decides when reset ends.

Top module: `rst_startup_seq`

## Requirements
- R1: While `rst_req_i` is 1, `core_rst_o` is 1 without waiting for any clock edge, `cfg_rd_o` is 0 and `phase_o` is 0.
- R2: `core_rst_o` falls only after all three phases have finished. The time from the falling edge of `rst_req_i` to release is at least SETTLE_NORM·Tslow + OSC_CYC·Tosc + CFG_WORDS·Tsys (or SETTLE_FAST in place of SETTLE_NORM), and exceeds this by no more than four periods per domain.
- R3: With `fast_boot_i` = 0, the first phase lasts SETTLE_NORM slow-clock cycles (8192 by default, about 64 ms).
- R4: With `fast_boot_i` = 1, the first phase lasts SETTLE_FAST slow-clock cycles (1024 by default, about 8 ms).
- R5: `fast_boot_i` is captured on the first slow-clock cycle after the reset request is released. Later changes to it have no effect on the current sequence.
- R6: The second phase starts only after the first phase has finished, and lasts OSC_CYC (6) cycles of the fast oscillator.
- R7: The third phase issues exactly CFG_WORDS (21) strobes on `cfg_rd_o`, one in each consecutive system-clock cycle. `cfg_addr_o` is 0, 1, … CFG_WORDS−1 in that order, and `cfg_rd_o` is 0 at every other time.
- R8: `phase_o` uses 0 for supply settling, 1 for oscillator stabilisation, 2 for configuration load and 3 for running. Between reset requests it never decreases, and it reads 3 once `core_rst_o` is 0.
- R9: If `rst_req_i` rises in any phase, or after release, the sequence is abandoned. After the next release it runs again in full from the first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_req_i | input | 1 | Reset request from any source, active high, asynchronous |
| slow_clk_i | input | 1 | Slow oscillator clock (about 128 kHz) for supply settling |
| osc_clk_i | input | 1 | Calibrated fast oscillator clock |
| sys_clk_i | input | 1 | System clock for the configuration load |
| fast_boot_i | input | 1 | 1 selects the short settling delay |
| core_rst_o | output | 1 | Internal reset, active high |
| cfg_rd_o | output | 1 | Read strobe to non-volatile storage |
| cfg_addr_o | output | AW | Word address of the configuration read |
| phase_o | output | 2 | Sequence phase status (0..3) |

## Verification
The bench goes after abort points spread over every phase and after release. A sequencer that kept any count across an abort would release early, and the measured release time would fall below the window. It runs the short and the long settling delays back to back and flips the strap part way through the first phase. A design that latched the strap late, or sampled it all the time, would give a release time that belongs to the other setting. Strobe monitoring catches a load that is one word short or long, skips or repeats an address, or strobes after reset is released. A status that steps backward is also reported.

// File: rtl/startup_pkg.sv
package startup_pkg;
    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_OSC    = 2'd1,
        PH_CFG    = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;
endpackage

// File: rtl/startup_sync2.sv
module startup_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[0], d_i};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) stg_q <= {2{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[1];
endmodule

// File: rtl/startup_settle.sv
module startup_settle #(
    parameter int SETTLE_NORM = 8192,
    parameter int SETTLE_FAST = 1024,
    localparam int CW = $clog2(SETTLE_NORM) + 1
) (
    input  logic clk_i,
    input  logic req_i,
    input  logic fast_i,
    output logic done_o
);
    typedef struct packed {
        logic          armed;
        logic          use_fast;
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t st_d, st_q;
    logic rst_n, rst;
    logic [CW-1:0] last_d;

    startup_sync2 #(.RST_VAL(1'b0)) u_rsync (
        .clk_i(clk_i), .arst_i(req_i), .d_i(1'b1), .q_o(rst_n)
    );
    assign rst = ~rst_n;

    always_comb begin
        last_d = st_q.use_fast ? CW'(SETTLE_FAST - 1) : CW'(SETTLE_NORM - 1);
        st_d   = st_q;
        if (!st_q.armed) begin
            st_d.armed    = 1'b1;
            st_d.use_fast = fast_i;
            st_d.cnt      = '0;
        end else if (!st_q.done) begin
            if (st_q.cnt == last_d) st_d.done = 1'b1;
            else                    st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done_o = st_q.done;

    // R5
    strap_hold_chk: assert property (@(posedge clk_i) disable iff (rst)
        st_q.armed |=> $stable(st_q.use_fast));
    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst)
        st_q.cnt <= CW'(SETTLE_NORM - 1));
    // R2
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (rst)
        st_q.done |=> st_q.done);
endmodule

// File: rtl/startup_stage.sv
module startup_stage #(
    parameter int CYC = 6,
    localparam int IW = (CYC > 1) ? $clog2(CYC) : 1
) (
    input  logic          clk_i,
    input  logic          req_i,
    input  logic          go_i,
    output logic          active_o,
    output logic [IW-1:0] idx_o,
    output logic          done_o
);
    typedef struct packed {
        logic [IW-1:0] idx;
        logic          active;
        logic          done;
    } st_t;

    st_t  st_d, st_q;
    logic rst_n, rst, go_s;

    startup_sync2 #(.RST_VAL(1'b0)) u_rsync (
        .clk_i(clk_i), .arst_i(req_i), .d_i(1'b1), .q_o(rst_n)
    );
    assign rst = ~rst_n;

    startup_sync2 #(.RST_VAL(1'b0)) u_gosync (
        .clk_i(clk_i), .arst_i(rst), .d_i(go_i), .q_o(go_s)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.idx == IW'(CYC - 1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (!st_q.done && go_s) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
        end
    end

    always_ff @(posedge clk_i or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign idx_o    = st_q.idx;
    assign done_o   = st_q.done;

    // R7
    step_chk: assert property (@(posedge clk_i) disable iff (rst)
        (active_o && idx_o != IW'(CYC - 1)) |=> (active_o && idx_o == $past(idx_o) + 1'b1));
    // R7
    single_run_chk: assert property (@(posedge clk_i) disable iff (rst)
        done_o |-> !active_o);
endmodule

// File: rtl/rst_startup_seq.sv
module rst_startup_seq #(
    parameter int SETTLE_NORM = 8192,
    parameter int SETTLE_FAST = 1024,
    parameter int OSC_CYC     = 6,
    parameter int CFG_WORDS   = 21,
    localparam int AW  = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1,
    localparam int OIW = (OSC_CYC > 1) ? $clog2(OSC_CYC) : 1
) (
    input  logic          rst_req_i,
    input  logic          slow_clk_i,
    input  logic          osc_clk_i,
    input  logic          sys_clk_i,
    input  logic          fast_boot_i,
    output logic          core_rst_o,
    output logic          cfg_rd_o,
    output logic [AW-1:0] cfg_addr_o,
    output logic [1:0]    phase_o
);
    import startup_pkg::*;

    logic           settle_done, osc_act, osc_done, cfg_done;
    logic [OIW-1:0] osc_idx;
    logic           sys_rst_n, sys_rst, settle_s, osc_s;
    phase_e         phase_d;

    startup_settle #(.SETTLE_NORM(SETTLE_NORM), .SETTLE_FAST(SETTLE_FAST)) u_settle (
        .clk_i(slow_clk_i), .req_i(rst_req_i), .fast_i(fast_boot_i), .done_o(settle_done)
    );

    startup_stage #(.CYC(OSC_CYC)) u_osc (
        .clk_i(osc_clk_i), .req_i(rst_req_i), .go_i(settle_done),
        .active_o(osc_act), .idx_o(osc_idx), .done_o(osc_done)
    );

    startup_stage #(.CYC(CFG_WORDS)) u_cfg (
        .clk_i(sys_clk_i), .req_i(rst_req_i), .go_i(osc_done),
        .active_o(cfg_rd_o), .idx_o(cfg_addr_o), .done_o(cfg_done)
    );

    startup_sync2 #(.RST_VAL(1'b0)) u_sys_rsync (
        .clk_i(sys_clk_i), .arst_i(rst_req_i), .d_i(1'b1), .q_o(sys_rst_n)
    );
    assign sys_rst = ~sys_rst_n;

    startup_sync2 #(.RST_VAL(1'b0)) u_settle_s (
        .clk_i(sys_clk_i), .arst_i(sys_rst), .d_i(settle_done), .q_o(settle_s)
    );
    startup_sync2 #(.RST_VAL(1'b0)) u_osc_s (
        .clk_i(sys_clk_i), .arst_i(sys_rst), .d_i(osc_done), .q_o(osc_s)
    );

    always_comb begin
        if (cfg_done)      phase_d = PH_RUN;
        else if (osc_s)    phase_d = PH_CFG;
        else if (settle_s) phase_d = PH_OSC;
        else               phase_d = PH_SETTLE;
    end

    assign phase_o    = phase_d;
    assign core_rst_o = rst_req_i | ~cfg_done;

    // R1
    req_forces_rst_chk: assert property (@(posedge sys_clk_i)
        rst_req_i |-> (core_rst_o && !cfg_rd_o));
    // R7
    no_late_strobe_chk: assert property (@(posedge sys_clk_i) disable iff (rst_req_i)
        !core_rst_o |-> !cfg_rd_o);
    // R8
    phase_mono_chk: assert property (@(posedge sys_clk_i) disable iff (sys_rst)
        phase_o >= $past(phase_o));
    // R6
    osc_after_settle_chk: assert property (@(posedge osc_clk_i) disable iff (rst_req_i)
        osc_act |-> (settle_done && osc_idx <= OIW'(OSC_CYC - 1)));
endmodule

// File: tb/test_rst_startup_seq.sv
`timescale 1ns/1ps
module test_rst_startup_seq;
    localparam int NORM = 40;
    localparam int FAST = 8;
    localparam int OSCN = 6;
    localparam int WORDS = 21;
    localparam int AW = $clog2(WORDS);
    localparam int TSYS = 10, TOSC = 14, TSLOW = 50;

    logic          rst_req = 1'b1;
    logic          slow_clk = 1'b0, osc_clk = 1'b0, sys_clk = 1'b0;
    logic          fast_boot = 1'b0;
    logic          core_rst, cfg_rd;
    logic [AW-1:0] cfg_addr;
    logic [1:0]    phase;

    int n_vec = 0, n_bad = 0;
    int n_strb = 0, addr_err = 0, late_strb = 0, ph_back = 0, last_ph = 0;
    bit finished = 0;

    always #(TSYS/2.0)  sys_clk  = ~sys_clk;
    always #(TOSC/2.0)  osc_clk  = ~osc_clk;
    always #(TSLOW/2.0) slow_clk = ~slow_clk;

    rst_startup_seq #(.SETTLE_NORM(NORM), .SETTLE_FAST(FAST), .OSC_CYC(OSCN), .CFG_WORDS(WORDS))
    i_rst_startup_seq (
        .rst_req_i(rst_req), .slow_clk_i(slow_clk), .osc_clk_i(osc_clk), .sys_clk_i(sys_clk),
        .fast_boot_i(fast_boot), .core_rst_o(core_rst), .cfg_rd_o(cfg_rd),
        .cfg_addr_o(cfg_addr), .phase_o(phase)
    );

    // strobe and status monitor, sampled away from the active edge
    always @(negedge sys_clk) begin
        if (rst_req) begin
            n_strb = 0; addr_err = 0; late_strb = 0; ph_back = 0; last_ph = 0;
        end else begin
            if (cfg_rd) begin
                if (int'(cfg_addr) != n_strb) addr_err++;
                n_strb++;
                if (!core_rst) late_strb++;
            end
            if (int'(phase) < last_ph) ph_back++;
            last_ph = int'(phase);
        end
    end

    function automatic longint lo_bound(bit fast);
        return longint'((fast ? FAST : NORM) * TSLOW + OSCN * TOSC + WORDS * TSYS);
    endfunction
    function automatic longint hi_bound(bit fast);
        return longint'(((fast ? FAST : NORM) + 4) * TSLOW + (OSCN + 4) * TOSC + (WORDS + 4) * TSYS);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // one full sequence; abort_ns > 0 re-asserts the request part way
    task automatic run_seq(input bit fast, input int abort_ns, input bit flip_strap);
        longint t0, dt;
        int guard;
        rst_req = 1'b1;
        fast_boot = fast;
        #(60);
        @(negedge sys_clk);
        // R1: reset state while request is held
        check(core_rst === 1'b1 && cfg_rd === 1'b0 && phase === 2'd0, "R1",
              longint'({core_rst, cfg_rd, phase}), 64'd8);
        rst_req = 1'b0;
        t0 = $time;
        if (abort_ns > 0) begin
            #(abort_ns);
            rst_req = 1'b1;
            #1;
            // R9 / R1: re-request forces reset immediately
            check(core_rst === 1'b1 && cfg_rd === 1'b0, "R9", longint'(core_rst), 1);
            #(40);
            rst_req = 1'b0;
            t0 = $time;
        end
        if (flip_strap) begin
            #(250);
            fast_boot = ~fast;
        end
        guard = 0;
        while (core_rst !== 1'b0 && guard < 20000) begin
            @(negedge sys_clk);
            guard++;
        end
        dt = $time - t0;
        // R2 / R3 / R4 / R5 / R6: release time window for the captured strap
        check(dt >= lo_bound(fast), fast ? "R4" : "R3", dt, lo_bound(fast));
        check(dt <= hi_bound(fast), flip_strap ? "R5" : "R2", dt, hi_bound(fast));
        // R7: strobe count, address order, nothing after release
        check(n_strb == WORDS, "R7", n_strb, WORDS);
        check(addr_err == 0 && late_strb == 0, "R7", addr_err + late_strb, 0);
        // R8: status reached run and never stepped back
        check(phase === 2'd3 && ph_back == 0, "R8", longint'(phase), 3);
        #(3 * TSYS);
        @(negedge sys_clk);
        check(cfg_rd === 1'b0 && core_rst === 1'b0, "R7", longint'(cfg_rd), 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0421);
        // directed corners
        run_seq(1'b0, 0, 1'b0);              // R3 long delay
        run_seq(1'b1, 0, 1'b0);              // R4 short delay
        run_seq(1'b1, 0, 1'b1);              // R5 strap flips to long mid-phase
        run_seq(1'b0, 0, 1'b1);              // R5 strap flips to short mid-phase
        run_seq(1'b0, 1200, 1'b0);           // R9 abort in settling
        run_seq(1'b0, int'(hi_bound(0)) - 150, 1'b0); // R9 abort near load
        run_seq(1'b1, 30, 1'b0);             // R9 abort right after release
        // constrained random
        for (int k = 0; k < 14; k++) begin
            bit f, fl;
            int ab;
            f  = 1'($urandom_range(0, 1));
            fl = ($urandom_range(0, 3) == 0);
            ab = ($urandom_range(0, 1) == 1) ? int'($urandom_range(20, int'(hi_bound(f)) + 200)) : 0;
            run_seq(f, ab, fl);
        end
        summary();
    end

    initial begin
        #(1_500_000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule